// File: doc/BRIEF.md
# USB Device Event Flag Register Block

This block gathers the endpoint 0 and power-management events of a USB device controller into sticky status bits that firmware clears by writing ones. Single-cycle pulses arrive from the serial engine: a packet received on endpoint 0, a packet transmitted on endpoint 0, the bus entering suspend, a K state seen on the bus, and a remote-wakeup request. The block keeps its own record of whether the device is suspended, so that K state and wakeup requests count only while the bus is asleep. Any set flag raises the main interrupt.

Firmware that cannot service a received control packet can pass it to a secondary interrupt path. It writes the redirect command bit together with the endpoint 0 receive bit. That write clears the receive flag and sets a redirect flag, which drives the DMA-side interrupt. A mode input selects how wakeup is signalled. In DMA signalling a separate sticky wake-event bit is set. In EPP signalling an active-low interrupt pin is pulled low while the wakeup flag is set. The block also holds the device address and a soft-disconnect control bit. The soft-disconnect bit tells the PHY to drive both data lines low.

Register map (address: content): 0 = event flags; 1 = auxiliary flags; 2 = device address; 3 = control. Reads are combinational from the address. Writes take effect at the clock edge on which `reg_wr` is sampled high.

Top module: `usbdev_evt_regs`

## Requirements
- R1: After reset, every register reads 0, `irq_main` and `irq_dma` are 0, `wake_evt` and `phy_se0` are 0, `dev_addr` is 0 and `int_n` is 1.
- R2: A pulse on `evt_ep0_rx` sets bit 0 of address 0, and a pulse on `evt_ep0_tx` sets bit 1 of address 0. Each bit is visible on the cycle after the pulse.
- R3: Writing 1 to a flag bit at address 0 clears that bit. Writing 0 leaves it unchanged.
- R4: A pulse on `evt_suspend` sets bit 2 of address 0 and puts the device in the suspended state.
- R5: A pulse on `evt_kstate` sets bit 3 of address 0 only while the device is suspended. A K state or a wakeup request taken while suspended ends the suspended state.
- R6: A pulse on `evt_wake_req` sets bit 4 of address 0 only while the device is suspended.
- R7: With `mode_epp`=0, a wakeup also sets bit 1 of address 1 (`wake_evt`, cleared by writing 1), and `int_n` stays 1. With `mode_epp`=1, `int_n` is 0 exactly while bit 4 of address 0 is set, and bit 1 of address 1 is not set.
- R8: Writing address 0 with bits 7 and 0 both 1 clears bit 0 and sets bit 0 of address 1 (`irq_dma`=1). Bit 7 written without bit 0 has no effect, and bit 7 always reads 0.
- R9: Bit 0 of address 1 is cleared by writing 1 to it, which drops `irq_dma`.
- R10: When a set pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R11: `irq_main` is 1 exactly when any of bits 4..0 of address 0 is set.
- R12: Address 2 bits 6..0 hold the device address, which is readable and appears on `dev_addr`. Address 3 bit 0 is the soft-disconnect bit, which drives `phy_se0`.
- R13: Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rdata | output | DATA_W (8) | Read data for `reg_addr` |
| evt_ep0_rx | input | 1 | Endpoint 0 packet received pulse |
| evt_ep0_tx | input | 1 | Endpoint 0 packet sent pulse |
| evt_suspend | input | 1 | Bus suspend detected pulse |
| evt_kstate | input | 1 | K state seen on the bus pulse |
| evt_wake_req | input | 1 | Remote-wakeup request pulse |
| mode_epp | input | 1 | 0 = DMA signalling, 1 = EPP signalling |
| irq_main | output | 1 | Main interrupt |
| irq_dma | output | 1 | Redirected control-receive interrupt |
| wake_evt | output | 1 | Sticky wake-event bit (DMA signalling) |
| int_n | output | 1 | Active-low wakeup pin (EPP signalling) |
| dev_addr | output | DEV_ADDR_W (7) | Device address |
| phy_se0 | output | 1 | Soft disconnect: drive D+ and D- low |

## Verification
The bench builds the block with its defaults: a 4-bit address, 8-bit data, a 7-bit device address, and the variant in which set has priority. The 4-bit address leaves twelve unmapped locations, so writes and reads away from the four live registers can be tested. The 7-bit address field also exposes the top write bit as one that cannot be stored. The set-priority variant makes the collision between a hardware event and a firmware clear deterministic to check. Both wakeup signalling modes are driven at run time through `mode_epp`, and so are suspend entry and exit.

// File: rtl/usbdev_evt_pkg.sv
package usbdev_evt_pkg;
   // flag positions at the event register
   localparam int unsigned FLG_EP0RX   = 0;
   localparam int unsigned FLG_EP0TX   = 1;
   localparam int unsigned FLG_SUSP    = 2;
   localparam int unsigned FLG_RESUME  = 3;
   localparam int unsigned FLG_WAKE    = 4;
   localparam int unsigned FLG_N       = 5;
   // auxiliary register positions
   localparam int unsigned AUX_CTL     = 0;
   localparam int unsigned AUX_WAKEVT  = 1;
   localparam int unsigned AUX_N       = 2;
   // register indices
   localparam int unsigned REG_FLAGS   = 0;
   localparam int unsigned REG_AUX     = 1;
   localparam int unsigned REG_DEVADR  = 2;
   localparam int unsigned REG_CTRL    = 3;
   localparam int unsigned CTRL_SE0    = 0;

   typedef struct packed {
      logic wake_req;
      logic kstate;
      logic suspend;
      logic ep0_tx;
      logic ep0_rx;
   } evt_pulse_t;
endpackage

// File: rtl/usbdev_w1c_bank.sv
module usbdev_w1c_bank #(
   parameter int unsigned N        = 5,
   parameter bit          SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   logic [N-1:0] q_r;

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic nxt;
      if (SET_WINS) begin : g_set_pri
         assign nxt = set_i[i] | (q_r[i] & ~clr_i[i]);
      end else begin : g_clr_pri
         assign nxt = (set_i[i] | q_r[i]) & ~clr_i[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r[i] <= 1'b0;
         else        q_r[i] <= nxt;
      end
   end

   assign q_o = q_r;
endmodule

// File: rtl/usbdev_pwr_track.sv
module usbdev_pwr_track (
   input  logic clk,
   input  logic rst_n,
   input  logic suspend_i,
   input  logic kstate_i,
   input  logic wake_req_i,
   output logic resume_o,
   output logic wake_o
);
   logic asleep_q;

   assign resume_o = kstate_i   & asleep_q;
   assign wake_o   = wake_req_i & asleep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   asleep_q <= 1'b0;
      else if (suspend_i)           asleep_q <= 1'b1;
      else if (resume_o || wake_o)  asleep_q <= 1'b0;
   end
endmodule

// File: rtl/usbdev_cfg_regs.sv
module usbdev_cfg_regs #(
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_addr_i,
   input  logic          wr_ctrl_i,
   input  logic [AW-1:0] addr_d_i,
   input  logic          se0_d_i,
   output logic [AW-1:0] dev_addr_o,
   output logic          se0_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_addr_o <= '0;
         se0_o      <= 1'b0;
      end else begin
         if (wr_addr_i) dev_addr_o <= addr_d_i;
         if (wr_ctrl_i) se0_o      <= se0_d_i;
      end
   end
endmodule

// File: rtl/usbdev_evt_regs.sv
module usbdev_evt_regs
   import usbdev_evt_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DEV_ADDR_W = 7,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  evt_ep0_rx,
   input  logic                  evt_ep0_tx,
   input  logic                  evt_suspend,
   input  logic                  evt_kstate,
   input  logic                  evt_wake_req,
   input  logic                  mode_epp,
   output logic                  irq_main,
   output logic                  irq_dma,
   output logic                  wake_evt,
   output logic                  int_n,
   output logic [DEV_ADDR_W-1:0] dev_addr,
   output logic                  phy_se0
);
   localparam int unsigned CMD_BIT = DATA_W - 1;

   initial begin
      if (DATA_W < 8)               $error("DATA_W must be at least 8");
      if (DEV_ADDR_W > DATA_W - 1)  $error("DEV_ADDR_W must fit below the top data bit");
      if (ADDR_W < 2)               $error("ADDR_W must reach four registers");
   end

   evt_pulse_t ev;
   assign ev = '{wake_req: evt_wake_req, kstate: evt_kstate, suspend: evt_suspend,
                 ep0_tx: evt_ep0_tx, ep0_rx: evt_ep0_rx};

   // write decode
   logic wr_flags, wr_aux, wr_devadr, wr_ctrl, redirect;
   assign wr_flags  = reg_wr && (reg_addr == ADDR_W'(REG_FLAGS));
   assign wr_aux    = reg_wr && (reg_addr == ADDR_W'(REG_AUX));
   assign wr_devadr = reg_wr && (reg_addr == ADDR_W'(REG_DEVADR));
   assign wr_ctrl   = reg_wr && (reg_addr == ADDR_W'(REG_CTRL));
   assign redirect  = wr_flags && reg_wdata[CMD_BIT] && reg_wdata[FLG_EP0RX];

   // suspend tracking
   logic resume_hit, wake_hit;
   usbdev_pwr_track u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .suspend_i  (ev.suspend),
      .kstate_i   (ev.kstate),
      .wake_req_i (ev.wake_req),
      .resume_o   (resume_hit),
      .wake_o     (wake_hit)
   );

   // main event flags
   logic [FLG_N-1:0] flg_set, flg_clr, flags_q;
   always_comb begin
      flg_set             = '0;
      flg_set[FLG_EP0RX]  = ev.ep0_rx;
      flg_set[FLG_EP0TX]  = ev.ep0_tx;
      flg_set[FLG_SUSP]   = ev.suspend;
      flg_set[FLG_RESUME] = resume_hit;
      flg_set[FLG_WAKE]   = wake_hit;
      flg_clr             = wr_flags ? reg_wdata[FLG_N-1:0] : '0;
   end

   usbdev_w1c_bank #(.N(FLG_N), .SET_WINS(SET_WINS)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flg_set),
      .clr_i (flg_clr),
      .q_o   (flags_q)
   );

   // auxiliary flags: redirect and DMA-side wake event
   logic [AUX_N-1:0] aux_set, aux_clr, aux_q;
   always_comb begin
      aux_set             = '0;
      aux_set[AUX_CTL]    = redirect;
      aux_set[AUX_WAKEVT] = wake_hit & ~mode_epp;
      aux_clr             = wr_aux ? reg_wdata[AUX_N-1:0] : '0;
   end

   usbdev_w1c_bank #(.N(AUX_N), .SET_WINS(SET_WINS)) u_aux (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (aux_set),
      .clr_i (aux_clr),
      .q_o   (aux_q)
   );

   // address and soft disconnect
   usbdev_cfg_regs #(.AW(DEV_ADDR_W)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_addr_i  (wr_devadr),
      .wr_ctrl_i  (wr_ctrl),
      .addr_d_i   (reg_wdata[DEV_ADDR_W-1:0]),
      .se0_d_i    (reg_wdata[CTRL_SE0]),
      .dev_addr_o (dev_addr),
      .se0_o      (phy_se0)
   );

   assign irq_main = |flags_q;
   assign irq_dma  = aux_q[AUX_CTL];
   assign wake_evt = aux_q[AUX_WAKEVT];
   assign int_n    = ~(mode_epp & flags_q[FLG_WAKE]);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(REG_FLAGS):  reg_rdata = DATA_W'(flags_q);
         ADDR_W'(REG_AUX):    reg_rdata = DATA_W'(aux_q);
         ADDR_W'(REG_DEVADR): reg_rdata = DATA_W'(dev_addr);
         ADDR_W'(REG_CTRL):   reg_rdata = DATA_W'(phy_se0);
         default:             reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/usbdev_evt_regs_chk.sv
module usbdev_evt_regs_chk #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DEV_ADDR_W = 7
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  reg_wr,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [DATA_W-1:0]     reg_wdata,
   input logic                  evt_ep0_rx,
   input logic                  evt_ep0_tx,
   input logic                  evt_suspend,
   input logic                  evt_kstate,
   input logic                  evt_wake_req,
   input logic                  mode_epp,
   input logic                  irq_main,
   input logic                  irq_dma,
   input logic                  wake_evt,
   input logic [4:0]            flags,
   input logic [DEV_ADDR_W-1:0] dev_addr
);
   // R2: a transmit pulse is latched
   a_r2_tx_latched: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ep0_tx |=> flags[1]);

   // R3: write-one clears when no set collides
   a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata[1] && !evt_ep0_tx) |=> !flags[1]);

   // R5: resume flag rises only after a K state
   a_r5_resume_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[3]) |-> $past(evt_kstate));

   // R6: wakeup flag rises only after a wake request
   a_r6_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[4]) |-> $past(evt_wake_req));

   // R7: in DMA signalling a new wakeup also sets the wake event bit
   a_r7_dma_wakevt: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[4]) && !$past(mode_epp)) |-> wake_evt);

   // R8: redirect command moves the packet to the DMA interrupt
   a_r8_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata[DATA_W-1] && reg_wdata[0] && !evt_ep0_rx)
      |=> (irq_dma && !flags[0]));

   // R11: the main interrupt rises only after an event
   a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_main) |-> $past(evt_ep0_rx || evt_ep0_tx || evt_suspend || evt_kstate || evt_wake_req));

   // R12: the address holds unless written
   a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == ADDR_W'(2)) |=> $stable(dev_addr));
endmodule

bind usbdev_evt_regs usbdev_evt_regs_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_ADDR_W(DEV_ADDR_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .evt_ep0_rx   (evt_ep0_rx),
   .evt_ep0_tx   (evt_ep0_tx),
   .evt_suspend  (evt_suspend),
   .evt_kstate   (evt_kstate),
   .evt_wake_req (evt_wake_req),
   .mode_epp     (mode_epp),
   .irq_main     (irq_main),
   .irq_dma      (irq_dma),
   .wake_evt     (wake_evt),
   .flags        (flags_q),
   .dev_addr     (dev_addr)
);

// File: tb/usbdev_evt_regs_tb_top.sv
`timescale 1ns/1ps
module usbdev_evt_regs_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       evt_ep0_rx = 1'b0, evt_ep0_tx = 1'b0, evt_suspend = 1'b0;
   logic       evt_kstate = 1'b0, evt_wake_req = 1'b0, mode_epp = 1'b0;
   logic       irq_main, irq_dma, wake_evt, int_n, phy_se0;
   logic [6:0] dev_addr;

   always #2 clk = ~clk;

   usbdev_evt_regs dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_ep0_rx(evt_ep0_rx), .evt_ep0_tx(evt_ep0_tx), .evt_suspend(evt_suspend),
      .evt_kstate(evt_kstate), .evt_wake_req(evt_wake_req), .mode_epp(mode_epp),
      .irq_main(irq_main), .irq_dma(irq_dma), .wake_evt(wake_evt), .int_n(int_n),
      .dev_addr(dev_addr), .phy_se0(phy_se0)
   );

   // observed quantities
   localparam int K_RD = 0, K_MAIN = 1, K_DMA = 2, K_INTN = 3, K_SE0 = 4, K_WEVT = 5, K_DADR = 6;
   typedef struct {
      int    kind;
      int    exp;
      string tag;
   } sb_item_t;
   sb_item_t sb_q[$];
   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // event bit order in tasks: {wake_req, kstate, suspend, tx, rx}
   task automatic cyc(input bit wr, input logic [3:0] a, input logic [7:0] d, input logic [4:0] ev);
      @(posedge clk); #1;
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      {evt_wake_req, evt_kstate, evt_suspend, evt_ep0_tx, evt_ep0_rx} = ev;
      @(posedge clk); #1;
      reg_wr = 1'b0;
      {evt_wake_req, evt_kstate, evt_suspend, evt_ep0_tx, evt_ep0_rx} = '0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      cyc(1'b1, a, d, 5'b0);
   endtask

   task automatic pulse(input logic [4:0] ev);
      cyc(1'b0, 4'd0, 8'd0, ev);
   endtask

   // driver: set up the read address and push the expected item
   task automatic expect_val(input int kind, input logic [3:0] a, input int exp, input string tag);
      sb_item_t it;
      if (kind == K_RD) reg_addr = a;
      it.kind = kind; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk); #1;
   endtask

   function automatic int observe(input int kind);
      case (kind)
         K_RD:    return int'(reg_rdata);
         K_MAIN:  return int'(irq_main);
         K_DMA:   return int'(irq_dma);
         K_INTN:  return int'(int_n);
         K_SE0:   return int'(phy_se0);
         K_WEVT:  return int'(wake_evt);
         default: return int'(dev_addr);
      endcase
   endfunction

   // monitor: compare every pending item at the falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         sb_item_t it;
         int got;
         it  = sb_q.pop_front();
         got = observe(it.kind);
         n_tests++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, got, it.exp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset values
      expect_val(K_RD, 0, 0, "R1 flags");
      expect_val(K_RD, 1, 0, "R1 aux");
      expect_val(K_RD, 2, 0, "R1 devadr");
      expect_val(K_RD, 3, 0, "R1 ctrl");
      expect_val(K_MAIN, 0, 0, "R1 irq_main");
      expect_val(K_DMA, 0, 0, "R1 irq_dma");
      expect_val(K_INTN, 0, 1, "R1 int_n");
      expect_val(K_SE0, 0, 0, "R1 phy_se0");
      expect_val(K_WEVT, 0, 0, "R1 wake_evt");
      expect_val(K_DADR, 0, 0, "R1 dev_addr");

      // R2, R3, R11
      pulse(5'b00001);
      expect_val(K_RD, 0, 8'h01, "R2 rx set");
      expect_val(K_MAIN, 0, 1, "R11 irq on rx");
      wr(0, 8'h02);
      expect_val(K_RD, 0, 8'h01, "R3 zero write keeps rx");
      wr(0, 8'h01);
      expect_val(K_RD, 0, 8'h00, "R3 rx cleared");
      expect_val(K_MAIN, 0, 0, "R11 irq drops");
      pulse(5'b00010);
      expect_val(K_RD, 0, 8'h02, "R2 tx set");
      expect_val(K_MAIN, 0, 1, "R11 irq on tx");
      wr(0, 8'h02);
      expect_val(K_RD, 0, 8'h00, "R3 tx cleared");

      // R5, R6 outside suspend
      pulse(5'b01000);
      expect_val(K_RD, 0, 8'h00, "R5 kstate awake ignored");
      pulse(5'b10000);
      expect_val(K_RD, 0, 8'h00, "R6 wake awake ignored");
      expect_val(K_RD, 1, 8'h00, "R6 no wake event");

      // R4, R6, R7 DMA signalling
      mode_epp = 1'b0;
      pulse(5'b00100);
      expect_val(K_RD, 0, 8'h04, "R4 suspend set");
      pulse(5'b10000);
      expect_val(K_RD, 0, 8'h14, "R6 wake in suspend");
      expect_val(K_RD, 1, 8'h02, "R7 dma wake event");
      expect_val(K_WEVT, 0, 1, "R7 wake_evt pin");
      expect_val(K_INTN, 0, 1, "R7 int_n high in dma");
      pulse(5'b01000);
      expect_val(K_RD, 0, 8'h14, "R5 suspend ended by wake");
      wr(0, 8'h1F);
      expect_val(K_RD, 0, 8'h00, "R3 clear all");
      expect_val(K_RD, 1, 8'h02, "R7 wake event sticky");
      wr(1, 8'h02);
      expect_val(K_RD, 1, 8'h00, "R7 wake event cleared");

      // R5 resume while suspended
      pulse(5'b00100);
      pulse(5'b01000);
      expect_val(K_RD, 0, 8'h0C, "R5 resume in suspend");
      pulse(5'b10000);
      expect_val(K_RD, 0, 8'h0C, "R6 wake after resume ignored");
      wr(0, 8'h1F);

      // R7 EPP signalling
      mode_epp = 1'b1;
      pulse(5'b00100);
      pulse(5'b10000);
      expect_val(K_RD, 0, 8'h14, "R7 epp wake flag");
      expect_val(K_INTN, 0, 0, "R7 int_n low");
      expect_val(K_RD, 1, 8'h00, "R7 no wake event in epp");
      wr(0, 8'h10);
      expect_val(K_INTN, 0, 1, "R7 int_n released");
      wr(0, 8'h1F);
      mode_epp = 1'b0;

      // R8, R9 redirect
      pulse(5'b00001);
      wr(0, 8'h81);
      expect_val(K_RD, 0, 8'h00, "R8 rx cleared by redirect");
      expect_val(K_RD, 1, 8'h01, "R8 ctl flag set");
      expect_val(K_DMA, 0, 1, "R8 irq_dma");
      expect_val(K_MAIN, 0, 0, "R8 irq_main idle");
      pulse(5'b00001);
      wr(0, 8'h80);
      expect_val(K_RD, 0, 8'h01, "R8 cmd alone no effect");
      wr(1, 8'h01);
      expect_val(K_RD, 1, 8'h00, "R9 ctl cleared");
      expect_val(K_DMA, 0, 0, "R9 irq_dma drops");
      wr(0, 8'h01);

      // R10 collision
      cyc(1'b1, 0, 8'h02, 5'b00010);
      expect_val(K_RD, 0, 8'h02, "R10 set wins");
      wr(0, 8'h02);

      // R12 address and soft disconnect
      wr(2, 8'hFF);
      expect_val(K_RD, 2, 8'h7F, "R12 devadr read");
      expect_val(K_DADR, 0, 8'h7F, "R12 dev_addr pin");
      wr(3, 8'h01);
      expect_val(K_SE0, 0, 1, "R12 se0 on");
      expect_val(K_RD, 3, 8'h01, "R12 ctrl read");
      wr(3, 8'h00);
      expect_val(K_SE0, 0, 0, "R12 se0 off");

      // R13 unmapped
      wr(5, 8'hFF);
      expect_val(K_RD, 5, 8'h00, "R13 unmapped read");
      expect_val(K_RD, 0, 8'h00, "R13 flags untouched");
      expect_val(K_RD, 2, 8'h7F, "R13 devadr untouched");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule